// File: doc/BRIEF.md
# Stochastic Binary Synapse Update Engine

This block keeps a small matrix of one-bit synapses, one row per postsynaptic neuron and one column per presynaptic input. A learning event names the firing postsynaptic neuron, gives the vector of presynaptic inputs that spiked, the sign of the post-minus-pre timing and a learning mode. The engine then walks the selected row one cell per clock. Each cell that its input marks and that does not yet hold the target value receives one programming attempt. The attempt succeeds only when a pseudo-random byte falls below a threshold. SET and RESET use separate thresholds, and a cell's threshold grows with its count of failed attempts. A cell marked as defective at initialization is frozen at ON or at OFF and no learning event can change it.

Initialization visits every cell and uses the same generator to decide whether the cell is defective, and if so which value it is stuck at. Working cells are set to a random ON or OFF value. The generator seed can be loaded, so every run can be reproduced. A registered read port returns any weight row. A counter reports how many programming attempts have been made since the last initialization.

Top module: `syn_update_engine`

## Requirements
- R1: After reset, `busy`, `done` and `pulse_count` are 0, every weight is 0 (so `rd_weights` reads 0), and every failed-attempt counter is 0.
- R2: The generator is a 16-bit Galois register that shifts right and, when the bit shifted out is 1, XORs mask 0xB400 (bits 15, 13, 12, 10) into the result. `seed_load` while idle loads `seed_value`, and a seed of 0 loads 1. The register advances exactly once for each cell step of an initialization or a learning event, and at no other time. In each step `rnd` is the value before the advance.
- R3: `init_start` while idle walks all N_POST×N_PRE cells, row 0 first and columns ascending within a row. In each cell step the cell is made defective if rnd[7:0] < `fault_rate`. A defective cell is stuck ON when rnd[15:8] < 179 (about 70 %) and stuck OFF otherwise. A working cell takes the value rnd[15]. The step clears all failed-attempt counters, and `pulse_count` clears at the start. The walk takes N_POST×N_PRE cycles, followed by `done`.
- R4: `learn_mode` sets the target value of an event. 0 selects timing-driven learning: SET when `learn_dt_pos`=1, RESET when it is 0. 1 selects inverted timing-driven learning: RESET when `learn_dt_pos`=1, SET when it is 0. 2 selects Hebbian learning, which always SETs. 3 selects anti-Hebbian learning, which always RESETs.
- R5: In a learning event, only cells of row `learn_post` whose bit in `learn_pre` is 1, that are not defective and whose value differs from the target receive an attempt. Each attempt adds 1 to `pulse_count`, which wraps at its width.
- R6: An attempt succeeds when rnd[7:0] is strictly below the effective threshold, which is min(255, base + fail_count × `prob_boost`). A base of 0 with a failed count of 0 never switches.
- R7: A failed attempt increments the cell's failed count, saturating at 2^CNT_W−1. A successful attempt writes the target value and clears the count. A cell that receives no attempt keeps its count.
- R8: The SET base is `set_prob`. The RESET base is `reset_prob` when that is below `set_prob`, and otherwise `set_prob`−1, or 0 when `set_prob` is 0.
- R9: A defective cell keeps its stuck value through every learning event.
- R10: A learning event takes N_PRE cycles. `done` is a single-cycle pulse in the cycle after the last step, and `busy` is high from the cycle after the start up to that last step. `rd_weights` shows row `rd_row` one cycle after it is presented.
- R11: `init_start`, `learn_start` and `seed_load` are ignored while `busy` is high. When both starts are high together while idle, initialization wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_load | input | 1 | Load generator seed (idle only) |
| seed_value | input | 16 | Seed value; 0 maps to 1 |
| init_start | input | 1 | Start initialization of the whole matrix |
| fault_rate | input | 8 | Defect threshold used during initialization |
| learn_start | input | 1 | Start a learning event |
| learn_pre | input | N_PRE | Presynaptic spike vector |
| learn_post | input | ROW_W | Index of the firing postsynaptic neuron |
| learn_dt_pos | input | 1 | 1 when post-minus-pre timing is positive |
| learn_mode | input | 2 | 0 timing, 1 inverted timing, 2 Hebbian, 3 anti-Hebbian |
| set_prob | input | 8 | SET base threshold |
| reset_prob | input | 8 | RESET base threshold (clamped below SET) |
| prob_boost | input | 8 | Threshold increase per failed attempt |
| rd_row | input | ROW_W | Row to read |
| rd_weights | output | N_PRE | Registered weights of the row read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pulse_count | output | PCNT_W | Programming attempts since the last initialization |

## Verification
A start that is sampled at a clock edge produces its first cell step at the next edge. `done` is therefore due exactly N_PRE edges after a learning start and N_POST×N_PRE edges after an initialization start. The bench counts edges from the start to `done` and compares that count with these numbers. Weights and `pulse_count` are read only after `done`. Each row is read back by presenting `rd_row` at a falling edge and sampling `rd_weights` at the next falling edge, one register later. Every result is compared with a cycle-free model in the bench. That model replays the generator bit by bit and the per-cell rules in the same visiting order.

// File: rtl/syn_pkg.sv
package syn_pkg;
  localparam int RND_W = 16;
  localparam logic [RND_W-1:0] GALOIS_MASK = 16'hB400;
  localparam logic [7:0] STUCK_ON_LIMIT = 8'd179;

  typedef enum logic [1:0] {
    MODE_TIMING     = 2'd0,
    MODE_TIMING_INV = 2'd1,
    MODE_HEBB       = 2'd2,
    MODE_HEBB_INV   = 2'd3
  } learn_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INIT  = 2'd1,
    ST_LEARN = 2'd2
  } eng_state_e;

  function automatic logic [RND_W-1:0] galois_next(input logic [RND_W-1:0] s);
    logic [RND_W-1:0] sh;
    sh = s >> 1;
    return s[0] ? (sh ^ GALOIS_MASK) : sh;
  endfunction

  function automatic logic [RND_W-1:0] seed_fix(input logic [RND_W-1:0] s);
    return (s == '0) ? RND_W'(1) : s;
  endfunction

  // 1 = SET target, 0 = RESET target
  function automatic logic target_is_set(input learn_mode_e m, input logic dt_pos);
    case (m)
      MODE_TIMING:     return dt_pos;
      MODE_TIMING_INV: return !dt_pos;
      MODE_HEBB:       return 1'b1;
      default:         return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] reset_base(input logic [7:0] p_set, input logic [7:0] p_rst);
    if (p_rst < p_set) return p_rst;
    return (p_set == 8'd0) ? 8'd0 : p_set - 8'd1;
  endfunction

  function automatic logic [7:0] eff_threshold(input logic [7:0] base, input int unsigned fails,
                                               input logic [7:0] boost);
    int unsigned sum;
    sum = int'(base) + fails * int'(boost);
    return (sum > 255) ? 8'hFF : 8'(sum);
  endfunction
endpackage

// File: rtl/syn_lfsr.sv
module syn_lfsr
  import syn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RND_W-1:0] seed,
  input  logic             step,
  output logic [RND_W-1:0] state
);
  always_ff @(posedge clk) begin
    if (!rst_n)    state <= RND_W'(1);
    else if (load) state <= seed_fix(seed);
    else if (step) state <= galois_next(state);
  end
endmodule

// File: rtl/syn_cell_array.sv
module syn_cell_array #(
  parameter int N_PRE  = 8,
  parameter int N_POST = 4,
  parameter int CNT_W  = 2,
  parameter int ROW_W  = 2,
  parameter int COL_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] cell_row,
  input  logic [COL_W-1:0] cell_col,
  input  logic             wr_en,
  input  logic             wr_w,
  input  logic             wr_stuck,
  input  logic [CNT_W-1:0] wr_cnt,
  output logic             cell_w,
  output logic             cell_stuck,
  output logic [CNT_W-1:0] cell_cnt,
  input  logic [ROW_W-1:0] rd_row,
  output logic [N_PRE-1:0] rd_weights
);
  logic [N_POST-1:0][N_PRE-1:0] w_vec;
  logic [N_POST-1:0][N_PRE-1:0] s_vec;
  logic [CNT_W-1:0] c_vec [N_POST][N_PRE];

  for (genvar r = 0; r < N_POST; r++) begin : g_row
    for (genvar c = 0; c < N_PRE; c++) begin : g_col
      logic             w_r;
      logic             s_r;
      logic [CNT_W-1:0] c_r;
      logic             sel;
      assign sel = wr_en && (cell_row == ROW_W'(r)) && (cell_col == COL_W'(c));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          w_r <= 1'b0;
          s_r <= 1'b0;
          c_r <= '0;
        end else if (sel) begin
          w_r <= wr_w;
          s_r <= wr_stuck;
          c_r <= wr_cnt;
        end
      end
      assign w_vec[r][c] = w_r;
      assign s_vec[r][c] = s_r;
      assign c_vec[r][c] = c_r;
    end
  end

  assign cell_w     = w_vec[cell_row][cell_col];
  assign cell_stuck = s_vec[cell_row][cell_col];
  assign cell_cnt   = c_vec[cell_row][cell_col];

  always_ff @(posedge clk) begin
    if (!rst_n) rd_weights <= '0;
    else        rd_weights <= w_vec[rd_row];
  end
endmodule

// File: rtl/syn_cell_decide.sv
module syn_cell_decide
  import syn_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             init_mode,
  input  logic             pre_bit,
  input  logic             set_dir,
  input  logic [7:0]       thr_set,
  input  logic [7:0]       thr_rst,
  input  logic [7:0]       boost,
  input  logic [7:0]       frate,
  input  logic [RND_W-1:0] rnd,
  input  logic             cur_w,
  input  logic             cur_stuck,
  input  logic [CNT_W-1:0] cur_cnt,
  output logic             nxt_w,
  output logic             nxt_stuck,
  output logic [CNT_W-1:0] nxt_cnt,
  output logic             pulse,
  output logic             flip
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [7:0] lo_b;
  logic [7:0] hi_b;
  logic [7:0] thr;
  logic       faulty;

  assign lo_b   = rnd[7:0];
  assign hi_b   = rnd[15:8];
  assign faulty = lo_b < frate;
  assign thr    = eff_threshold(set_dir ? thr_set : thr_rst, int'(cur_cnt), boost);

  always_comb begin
    pulse     = 1'b0;
    flip      = 1'b0;
    nxt_w     = cur_w;
    nxt_stuck = cur_stuck;
    nxt_cnt   = cur_cnt;
    if (init_mode) begin
      nxt_stuck = faulty;
      nxt_w     = faulty ? (hi_b < STUCK_ON_LIMIT) : rnd[15];
      nxt_cnt   = '0;
    end else begin
      pulse = pre_bit && !cur_stuck && (cur_w != set_dir);
      flip  = pulse && (lo_b < thr);
      if (flip) begin
        nxt_w   = set_dir;
        nxt_cnt = '0;
      end else if (pulse && cur_cnt != CNT_MAX) begin
        nxt_cnt = cur_cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/syn_update_engine.sv
module syn_update_engine
  import syn_pkg::*;
#(
  parameter int N_PRE  = 8,
  parameter int N_POST = 4,
  parameter int CNT_W  = 2,
  parameter int PCNT_W = 16,
  localparam int ROW_W = (N_POST > 1) ? $clog2(N_POST) : 1,
  localparam int COL_W = (N_PRE > 1) ? $clog2(N_PRE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_load,
  input  logic [15:0]       seed_value,
  input  logic              init_start,
  input  logic [7:0]        fault_rate,
  input  logic              learn_start,
  input  logic [N_PRE-1:0]  learn_pre,
  input  logic [ROW_W-1:0]  learn_post,
  input  logic              learn_dt_pos,
  input  logic [1:0]        learn_mode,
  input  logic [7:0]        set_prob,
  input  logic [7:0]        reset_prob,
  input  logic [7:0]        prob_boost,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [N_PRE-1:0]  rd_weights,
  output logic              busy,
  output logic              done,
  output logic [PCNT_W-1:0] pulse_count
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(N_POST - 1);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(N_PRE - 1);

  eng_state_e       st;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [N_PRE-1:0] pre_q;
  logic             set_q;
  logic [7:0]       thr_set_q;
  logic [7:0]       thr_rst_q;
  logic [7:0]       boost_q;
  logic [7:0]       frate_q;

  // named internal events, observed by the checker
  logic             in_init;
  logic             in_learn;
  logic             cell_step;
  logic             last_step;
  logic [RND_W-1:0] lfsr_q;
  logic             cell_w;
  logic             cell_stuck;
  logic [CNT_W-1:0] cell_cnt;
  logic             wr_w;
  logic             wr_stuck;
  logic [CNT_W-1:0] wr_cnt;
  logic             cell_pulse;
  logic             cell_flip;
  logic             idle_now;

  assign in_init   = (st == ST_INIT);
  assign in_learn  = (st == ST_LEARN);
  assign cell_step = in_init || in_learn;
  assign idle_now  = (st == ST_IDLE);
  assign last_step = (col_q == LAST_COL) && (in_learn || (row_q == LAST_ROW));
  assign busy      = cell_step;

  syn_lfsr u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (seed_load && idle_now),
    .seed  (seed_value),
    .step  (cell_step),
    .state (lfsr_q)
  );

  syn_cell_array #(
    .N_PRE (N_PRE),
    .N_POST(N_POST),
    .CNT_W (CNT_W),
    .ROW_W (ROW_W),
    .COL_W (COL_W)
  ) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .cell_row  (row_q),
    .cell_col  (col_q),
    .wr_en     (cell_step),
    .wr_w      (wr_w),
    .wr_stuck  (wr_stuck),
    .wr_cnt    (wr_cnt),
    .cell_w    (cell_w),
    .cell_stuck(cell_stuck),
    .cell_cnt  (cell_cnt),
    .rd_row    (rd_row),
    .rd_weights(rd_weights)
  );

  syn_cell_decide #(.CNT_W(CNT_W)) u_decide (
    .init_mode(in_init),
    .pre_bit  (pre_q[col_q]),
    .set_dir  (set_q),
    .thr_set  (thr_set_q),
    .thr_rst  (thr_rst_q),
    .boost    (boost_q),
    .frate    (frate_q),
    .rnd      (lfsr_q),
    .cur_w    (cell_w),
    .cur_stuck(cell_stuck),
    .cur_cnt  (cell_cnt),
    .nxt_w    (wr_w),
    .nxt_stuck(wr_stuck),
    .nxt_cnt  (wr_cnt),
    .pulse    (cell_pulse),
    .flip     (cell_flip)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      row_q       <= '0;
      col_q       <= '0;
      pre_q       <= '0;
      set_q       <= 1'b0;
      thr_set_q   <= '0;
      thr_rst_q   <= '0;
      boost_q     <= '0;
      frate_q     <= '0;
      done        <= 1'b0;
      pulse_count <= '0;
    end else begin
      done <= 1'b0;
      if (idle_now) begin
        if (init_start) begin
          st          <= ST_INIT;
          row_q       <= '0;
          col_q       <= '0;
          frate_q     <= fault_rate;
          pulse_count <= '0;
        end else if (learn_start) begin
          st        <= ST_LEARN;
          row_q     <= learn_post;
          col_q     <= '0;
          pre_q     <= learn_pre;
          set_q     <= target_is_set(learn_mode_e'(learn_mode), learn_dt_pos);
          thr_set_q <= set_prob;
          thr_rst_q <= reset_base(set_prob, reset_prob);
          boost_q   <= prob_boost;
        end
      end else begin
        if (cell_pulse) pulse_count <= pulse_count + PCNT_W'(1);
        if (last_step) begin
          st   <= ST_IDLE;
          done <= 1'b1;
        end else if (col_q == LAST_COL) begin
          col_q <= '0;
          row_q <= row_q + ROW_W'(1);
        end else begin
          col_q <= col_q + COL_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/syn_update_checker.sv
module syn_update_checker #(
  parameter int PCNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              in_learn,
  input logic              init_start,
  input logic              cell_pulse,
  input logic              cell_flip,
  input logic              cell_stuck,
  input logic              cell_w,
  input logic              wr_w,
  input logic [15:0]       lfsr_q,
  input logic [PCNT_W-1:0] pulse_count
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && done) |-> (!busy && $past(busy)));

  assert_lfsr_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 16'd0);

  assert_stuck_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_learn && cell_stuck) |-> (wr_w == cell_w));

  assert_flip_needs_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cell_flip |-> cell_pulse);

  assert_pulse_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(in_learn)) |->
      (pulse_count == $past(pulse_count) + PCNT_W'($past(cell_pulse))));

  assert_pulse_count_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(busy) && !$past(init_start)) |-> $stable(pulse_count));
endmodule

bind syn_update_engine syn_update_checker #(.PCNT_W(PCNT_W)) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .in_learn   (in_learn),
  .init_start (init_start),
  .cell_pulse (cell_pulse),
  .cell_flip  (cell_flip),
  .cell_stuck (cell_stuck),
  .cell_w     (cell_w),
  .wr_w       (wr_w),
  .lfsr_q     (lfsr_q),
  .pulse_count(pulse_count)
);

// File: tb/test_syn_update_engine.sv
module test_syn_update_engine;
  localparam int NP = 8;
  localparam int NQ = 4;
  localparam int CW = 2;
  localparam int PW = 16;
  localparam int RW = 2;
  localparam int CMAX = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          seed_load = 1'b0;
  logic [15:0]   seed_value = '0;
  logic          init_start = 1'b0;
  logic [7:0]    fault_rate = '0;
  logic          learn_start = 1'b0;
  logic [NP-1:0] learn_pre = '0;
  logic [RW-1:0] learn_post = '0;
  logic          learn_dt_pos = 1'b0;
  logic [1:0]    learn_mode = '0;
  logic [7:0]    set_prob = '0;
  logic [7:0]    reset_prob = '0;
  logic [7:0]    prob_boost = '0;
  logic [RW-1:0] rd_row = '0;
  logic [NP-1:0] rd_weights;
  logic          busy;
  logic          done;
  logic [PW-1:0] pulse_count;

  always #10 clk = ~clk;

  syn_update_engine #(.N_PRE(NP), .N_POST(NQ), .CNT_W(CW), .PCNT_W(PW)) i_syn_update_engine (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_value(seed_value),
    .init_start(init_start), .fault_rate(fault_rate), .learn_start(learn_start),
    .learn_pre(learn_pre), .learn_post(learn_post), .learn_dt_pos(learn_dt_pos),
    .learn_mode(learn_mode), .set_prob(set_prob), .reset_prob(reset_prob),
    .prob_boost(prob_boost), .rd_row(rd_row), .rd_weights(rd_weights),
    .busy(busy), .done(done), .pulse_count(pulse_count)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  // reference state
  logic [15:0] m_rng;
  logic        m_w   [NQ][NP];
  logic        m_stk [NQ][NP];
  int          m_cnt [NQ][NP];
  logic [PW-1:0] m_pc;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  // bitwise restatement of the right-shifting Galois step, taps at 15,13,12,10
  function automatic logic [15:0] ref_step(input logic [15:0] s);
    logic [15:0] n;
    logic b;
    b = s[0];
    for (int i = 0; i < 15; i++) n[i] = s[i+1];
    n[15] = b;
    n[13] = s[14] ^ b;
    n[12] = s[13] ^ b;
    n[10] = s[11] ^ b;
    return n;
  endfunction

  task automatic model_init(input int fr);
    for (int r = 0; r < NQ; r++)
      for (int c = 0; c < NP; c++) begin
        int lo, hi;
        lo = int'(m_rng[7:0]);
        hi = int'(m_rng[15:8]);
        m_stk[r][c] = (lo < fr);
        m_w[r][c]   = m_stk[r][c] ? (hi < 179) : m_rng[15];
        m_cnt[r][c] = 0;
        m_rng = ref_step(m_rng);
      end
    m_pc = '0;
  endtask

  task automatic model_learn(input int post, input logic [NP-1:0] pre, input int mode,
                             input bit dt, input int ps, input int pr, input int bst);
    bit tgt;
    int base_r, base;
    case (mode)
      0: tgt = dt;
      1: tgt = !dt;
      2: tgt = 1'b1;
      default: tgt = 1'b0;
    endcase
    base_r = (pr < ps) ? pr : ((ps == 0) ? 0 : ps - 1);
    base = tgt ? ps : base_r;
    for (int c = 0; c < NP; c++) begin
      int lo, thr;
      lo = int'(m_rng[7:0]);
      if (pre[c] && !m_stk[post][c] && (m_w[post][c] != tgt)) begin
        m_pc = m_pc + 1'b1;
        thr = base + m_cnt[post][c] * bst;
        if (thr > 255) thr = 255;
        if (lo < thr) begin
          m_w[post][c] = tgt;
          m_cnt[post][c] = 0;
        end else if (m_cnt[post][c] < CMAX) begin
          m_cnt[post][c]++;
        end
      end
      m_rng = ref_step(m_rng);
    end
  endtask

  task automatic cmp_rows(input string tag);
    for (int r = 0; r < NQ; r++) begin
      logic [NP-1:0] exp_row;
      for (int c = 0; c < NP; c++) exp_row[c] = m_w[r][c];
      @(negedge clk) rd_row = RW'(r);
      @(posedge clk);
      @(negedge clk);
      chk(rd_weights == exp_row, tag, $sformatf("row %0d weights", r), rd_weights, exp_row);
    end
  endtask

  task automatic wait_done(output int lat, input bit poke);
    lat = 0;
    while (!done && lat < 200) begin
      if (poke && lat == 0) begin
        init_start  = 1'b1;
        learn_start = 1'b1;
        seed_load   = 1'b1;
        seed_value  = 16'h1234;
      end
      @(posedge clk);
      lat++;
      @(negedge clk);
      init_start  = 1'b0;
      learn_start = 1'b0;
      seed_load   = 1'b0;
    end
  endtask

  task automatic do_seed(input logic [15:0] s);
    @(negedge clk);
    seed_load = 1'b1;
    seed_value = s;
    @(posedge clk);
    @(negedge clk) seed_load = 1'b0;
    m_rng = (s == 16'd0) ? 16'd1 : s;
  endtask

  task automatic do_init(input int fr, input string tag);
    int lat;
    @(negedge clk);
    init_start = 1'b1;
    fault_rate = 8'(fr);
    model_init(fr);
    @(posedge clk);
    @(negedge clk) init_start = 1'b0;
    wait_done(lat, 1'b0);
    chk(lat == NQ * NP, "R3", "init latency", lat, NQ * NP);
    chk(pulse_count == '0, "R3", "pulse count after init", pulse_count, 0);
    cmp_rows(tag);
  endtask

  task automatic do_learn(input int post, input logic [NP-1:0] pre, input int mode,
                          input bit dt, input int ps, input int pr, input int bst,
                          input string tag, input bit poke);
    int lat;
    @(negedge clk);
    learn_start = 1'b1;
    learn_post = RW'(post);
    learn_pre = pre;
    learn_mode = 2'(mode);
    learn_dt_pos = dt;
    set_prob = 8'(ps);
    reset_prob = 8'(pr);
    prob_boost = 8'(bst);
    model_learn(post, pre, mode, dt, ps, pr, bst);
    @(posedge clk);
    @(negedge clk) learn_start = 1'b0;
    wait_done(lat, poke);
    chk(lat == NP, poke ? "R11" : "R10", "learn latency", lat, NP);
    chk(pulse_count == m_pc, "R5", "pulse count", pulse_count, m_pc);
    cmp_rows(tag);
  endtask

  function automatic logic [NP-1:0] pattern(input int k);
    logic [NP-1:0] p;
    for (int b = 0; b < NP; b++)
      case (k)
        0: p[b] = 1'b1;
        1: p[b] = (b % 2 == 0);
        default: p[b] = (b < NP / 2);
      endcase
    return p;
  endfunction

  task automatic sweep(input int ps, input int pr, input int bst, input string tag);
    for (int m = 0; m < 4; m++)
      for (int d = 0; d < 2; d++)
        for (int r = 0; r < NQ; r++)
          for (int k = 0; k < 3; k++)
            do_learn(r, pattern(k), m, d[0], ps, pr, bst, tag, 1'b0);
  endtask

  initial begin
    for (int r = 0; r < NQ; r++)
      for (int c = 0; c < NP; c++) begin
        m_w[r][c] = 1'b0;
        m_stk[r][c] = 1'b0;
        m_cnt[r][c] = 0;
      end
    m_rng = 16'd1;
    m_pc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(pulse_count == '0, "R1", "pulse count after reset", pulse_count, 0);
    cmp_rows("R1");

    // R2: zero seed maps to one, generator replayed through init
    do_seed(16'h0000);
    do_init(0, "R2");
    sweep(200, 60, 40, "R4");
    // R6: zero thresholds never switch, attempts still counted
    sweep(0, 0, 0, "R6");
    // R7: cumulative threshold from failed attempts
    sweep(0, 0, 128, "R7");
    // R8: RESET base clamped below SET base
    sweep(90, 200, 0, "R8");

    // R3 and R9: defects, then maximal thresholds
    do_seed(16'hA5C3);
    do_init(100, "R3");
    sweep(255, 255, 255, "R9");
    begin
      int nstk = 0;
      for (int r = 0; r < NQ; r++)
        for (int c = 0; c < NP; c++) if (m_stk[r][c]) nstk++;
      chk(nstk > 0, "R9", "defective cells present", nstk, 1);
    end

    // R11: starts and seed load during busy are ignored
    do_learn(1, pattern(0), 2, 1'b1, 128, 40, 20, "R11", 1'b1);
    do_learn(2, pattern(1), 3, 1'b0, 128, 40, 20, "R11", 1'b1);

    // R11: simultaneous starts while idle, initialization wins
    begin
      int lat;
      @(negedge clk);
      init_start = 1'b1;
      learn_start = 1'b1;
      fault_rate = 8'd30;
      model_init(30);
      @(posedge clk);
      @(negedge clk);
      init_start = 1'b0;
      learn_start = 1'b0;
      wait_done(lat, 1'b0);
      chk(lat == NQ * NP, "R11", "init wins latency", lat, NQ * NP);
      cmp_rows("R11");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule